// File: doc/BRIEF.md
# I2C Byte-Write Target for Non-Volatile Memory

This block is a two-wire serial bus target that accepts single-byte writes into an attached non-volatile memory. It samples the clock and data lines through synchronizers and drives the data line only by pulling it low. A transfer names the device, then gives a byte address, then one data byte. The block acknowledges each of the three bytes. It passes the write to the memory only when the bus controller closes the transfer with a STOP.

The device address starts with the fixed prefix 1010. The three bits after it are either compared with strap pins or taken as upper memory-address bits, as set by the `MEM_KBIT` parameter. After it issues the write strobe, the block ignores the bus until the memory reports that it is no longer busy.

Top module: `nvm_i2c_writer`

## Requirements
- R1: With `MEM_KBIT` of 1 or 2, the target acknowledges a device byte only if its bits [7:4] are 1010, its bits [3:1] equal `strap[2:0]` and bit 0 (R/W) is 0. The memory address is then the byte address, with bits [9:8] at zero.
- R2: With `MEM_KBIT` of 4, device bit 1 is not compared. Only bits [3:2] are checked against `strap[2:1]`, and device bit 1 becomes memory address bit 8.
- R3: With `MEM_KBIT` of 8, only device bit 3 is checked against `strap[2]`. Device bit 2 becomes memory address bit 9 and device bit 1 becomes bit 8.
- R4: For an accepted device byte, and for the byte address and data byte that follow it, `sda_oe` is high throughout the ninth SCL pulse. `sda_oe` changes only at a point where the synchronized SCL is low.
- R5: A device byte with R/W equal to 1 is not acknowledged. The target then ignores the rest of the transfer and issues no write.
- R6: After an acknowledged data byte, a STOP produces exactly one single-cycle `mem_we` pulse. During that pulse `mem_addr` holds the full address and `mem_data` holds the data byte.
- R7: A STOP that arrives before the data byte has been acknowledged produces no `mem_we`.
- R8: From the `mem_we` pulse until the first later cycle in which `mem_busy` is low, the target drives no acknowledge and ignores any START. A START that is detected in the same cycle as that low `mem_busy` is also ignored.
- R9: A repeated START at any point before STOP drops the partly received sequence. Reception starts again with a new device byte.
- R10: After reset, `sda_oe` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line |
| strap | input | 3 | Device-select strap pins |
| sda_oe | output | 1 | When high, pull the data line low |
| mem_addr | output | 10 | Memory byte address |
| mem_data | output | 8 | Memory write data |
| mem_write | output | 1 | Not used; see mem_we |
| mem_we | output | 1 | Single-cycle memory write strobe |
| mem_busy | input | 1 | Memory write in progress |

## Verification
Two functions can land on the same clock edge: the memory's busy flag falling, which ends the deaf period, and a START from the controller being detected. The bench lines these up exactly. It drops the data line at a known edge and releases `mem_busy` so that the target first sees it low in the cycle in which the START detector fires. The target must treat that START as ignored. The bench judges this by the missing acknowledge on the device byte that follows, and by the absence of a second write. A fresh transfer after that must be acknowledged and written normally.

// File: rtl/nvm_i2c_writer.sv
module nvm_i2c_writer #(
  parameter int         MEM_KBIT   = 2,
  parameter logic [3:0] DEV_PREFIX = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap,
  output logic       sda_oe,
  output logic [9:0] mem_addr,
  output logic [7:0] mem_data,
  output logic       mem_write,
  output logic       mem_we,
  input  logic       mem_busy
);

  localparam logic [2:0] CMP_MASK = (MEM_KBIT >= 8) ? 3'b100 :
                                    (MEM_KBIT == 4) ? 3'b110 : 3'b111;

  typedef enum logic [2:0] {IDLE, RECV, ACK, HOLD, COMMIT, WAIT} st_t;

  st_t        st;
  logic [2:0] scl_sh, sda_sh;
  logic [7:0] sr, lo, dat;
  logic [3:0] bitn;
  logic [1:0] phase, page;

  logic scl_rise, scl_fall, start_det, stop_det, dev_ok, busy;

  assign scl_rise  = scl_sh[1] & ~scl_sh[2];
  assign scl_fall  = ~scl_sh[1] & scl_sh[2];
  assign start_det = scl_sh[1] & scl_sh[2] & ~sda_sh[1] & sda_sh[2];
  assign stop_det  = scl_sh[1] & scl_sh[2] & sda_sh[1] & ~sda_sh[2];
  assign dev_ok    = (sr[7:4] == DEV_PREFIX) && (((sr[3:1] ^ strap) & CMP_MASK) == 3'b000) && !sr[0];
  assign busy      = (st == COMMIT) || (st == WAIT);

  assign mem_addr  = {page, lo};
  assign mem_data  = dat;
  assign mem_we    = (st == COMMIT);
  assign mem_write = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      sr     <= '0;
      lo     <= '0;
      dat    <= '0;
      bitn   <= '0;
      phase  <= '0;
      page   <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        COMMIT: st <= WAIT;
        WAIT:   if (!mem_busy) st <= IDLE;
        default: begin
          if (start_det) begin
            st     <= RECV;
            bitn   <= '0;
            phase  <= '0;
            sda_oe <= 1'b0;
          end else if (stop_det) begin
            st     <= (st == HOLD) ? COMMIT : IDLE;
            sda_oe <= 1'b0;
          end else begin
            case (st)
              RECV: begin
                if (scl_rise && bitn < 4'd8) begin
                  sr   <= {sr[6:0], sda_sh[1]};
                  bitn <= bitn + 4'd1;
                end else if (scl_fall && bitn == 4'd8) begin
                  if (phase == 2'd0) begin
                    if (dev_ok) begin
                      sda_oe <= 1'b1;
                      st     <= ACK;
                      page   <= sr[2:1] & ~CMP_MASK[1:0];
                    end else begin
                      st <= IDLE;
                    end
                  end else begin
                    if (phase == 2'd1) lo <= sr;
                    else               dat <= sr;
                    sda_oe <= 1'b1;
                    st     <= ACK;
                  end
                end
              end
              ACK: begin
                if (scl_fall) begin
                  sda_oe <= 1'b0;
                  bitn   <= '0;
                  if (phase == 2'd2) begin
                    st <= HOLD;
                  end else begin
                    phase <= phase + 2'd1;
                    st    <= RECV;
                  end
                end
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/nvm_i2c_writer_chk.sv
module nvm_i2c_writer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       mem_we,
  input logic       scl_q,
  input logic       stop_det,
  input logic       busy,
  input logic [9:0] mem_addr
);

  assert_we_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_we_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(stop_det));

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $stable(mem_addr));

  assert_oe_moves_low_scl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_q));

  assert_deaf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

endmodule

bind nvm_i2c_writer nvm_i2c_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .mem_we(mem_we),
  .scl_q(scl_sh[1]), .stop_det(stop_det), .busy(busy), .mem_addr(mem_addr)
);

// File: tb/nvm_i2c_writer_bench.sv
`timescale 1ns/1ps
module nvm_i2c_writer_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] oe, we, line, mbusy, clr;
  logic [2:0] unused_w;
  logic [9:0] addr [3];
  logic [7:0] data [3];
  int wcnt [3];
  logic [9:0] waddr [3];
  logic [7:0] wdata [3];
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign line = {3{sda_m}} & ~oe;

  nvm_i2c_writer #(.MEM_KBIT(2)) u_nvm_i2c_writer (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line[0]), .strap(3'b101),
    .sda_oe(oe[0]), .mem_addr(addr[0]), .mem_data(data[0]), .mem_write(unused_w[0]),
    .mem_we(we[0]), .mem_busy(mbusy[0]));
  nvm_i2c_writer #(.MEM_KBIT(4)) u_k4 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line[1]), .strap(3'b011),
    .sda_oe(oe[1]), .mem_addr(addr[1]), .mem_data(data[1]), .mem_write(unused_w[1]),
    .mem_we(we[1]), .mem_busy(mbusy[1]));
  nvm_i2c_writer #(.MEM_KBIT(8)) u_k8 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line[2]), .strap(3'b010),
    .sda_oe(oe[2]), .mem_addr(addr[2]), .mem_data(data[2]), .mem_write(unused_w[2]),
    .mem_we(we[2]), .mem_busy(mbusy[2]));

  always @(posedge clk) begin
    for (int k = 0; k < 3; k++) begin
      if (!rst_n) begin
        wcnt[k]  <= 0;
        mbusy[k] <= 1'b0;
      end else if (we[k]) begin
        wcnt[k]  <= wcnt[k] + 1;
        waddr[k] <= addr[k];
        wdata[k] <= data[k];
        mbusy[k] <= 1'b1;
      end else if (clr[k]) begin
        mbusy[k] <= 1'b0;
      end
    end
  end

  function automatic logic [2:0] strap_of(int k);
    return (k == 0) ? 3'b101 : (k == 1) ? 3'b011 : 3'b010;
  endfunction

  function automatic logic [2:0] mask_of(int k);
    return (k == 0) ? 3'b111 : (k == 1) ? 3'b110 : 3'b100;
  endfunction

  function automatic bit exp_match(int k, logic [7:0] dev);
    return dev[7:4] == 4'b1010 && ((dev[3:1] ^ strap_of(k)) & mask_of(k)) == 3'b000 && dev[0] == 1'b0;
  endfunction

  function automatic logic [9:0] exp_addr(int k, logic [7:0] dev, logic [7:0] lo);
    logic [2:0] m;
    m = mask_of(k);
    return {dev[2] & ~m[1], dev[1] & ~m[0], lo};
  endfunction

  task automatic tk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic m_start;
    sda_m = 1'b1; tk(4);
    scl_m = 1'b1; tk(8);
    sda_m = 1'b0; tk(8);
    scl_m = 1'b0; tk(4);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; tk(4);
    scl_m = 1'b1; tk(8);
    sda_m = 1'b1; tk(8);
  endtask

  task automatic m_byte(input logic [7:0] b, output logic [2:0] ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tk(4);
      scl_m = 1'b1; tk(8);
      scl_m = 1'b0; tk(4);
    end
    sda_m = 1'b1; tk(4);
    scl_m = 1'b1; tk(4);
    ack = ~line;
    tk(4);
    scl_m = 1'b0; tk(4);
  endtask

  task automatic check_acks(logic [2:0] ack, logic [7:0] dev, logic [2:0] deaf, string req, string what);
    for (int k = 0; k < 3; k++) begin
      bit e;
      e = exp_match(k, dev) && !deaf[k];
      chk(ack[k] == e, req, what, int'(ack[k]), int'(e));
    end
  endtask

  task automatic full_write(logic [7:0] dev, logic [7:0] lo, logic [7:0] d, logic [2:0] deaf, string req);
    int p [3];
    logic [2:0] a;
    for (int k = 0; k < 3; k++) p[k] = wcnt[k];
    m_start;
    m_byte(dev, a); check_acks(a, dev, deaf, req, "device ack");
    m_byte(lo, a);  check_acks(a, dev, deaf, req, "address ack");
    m_byte(d, a);   check_acks(a, dev, deaf, req, "data ack");
    m_stop;
    tk(12);
    for (int k = 0; k < 3; k++) begin
      if (exp_match(k, dev) && !deaf[k]) begin
        chk(wcnt[k] == p[k] + 1, req, "write count", wcnt[k], p[k] + 1);
        chk(waddr[k] == exp_addr(k, dev, lo), req, "write address", int'(waddr[k]), int'(exp_addr(k, dev, lo)));
        chk(wdata[k] == d, req, "write data", int'(wdata[k]), int'(d));
      end else begin
        chk(wcnt[k] == p[k], req, "no write", wcnt[k], p[k]);
      end
    end
  endtask

  task automatic t_reset;
    chk(oe == 3'b000, "R10", "sda_oe after reset", int'(oe), 0);
    chk(we == 3'b000, "R10", "mem_we after reset", int'(we), 0);
    chk(wcnt[0] + wcnt[1] + wcnt[2] == 0, "R10", "writes after reset", wcnt[0] + wcnt[1] + wcnt[2], 0);
  endtask

  task automatic t_match_r1;
    full_write(8'b1010_101_0, 8'h5C, 8'hA7, 3'b000, "R1");
    full_write(8'b1010_100_0, 8'h01, 8'h02, 3'b000, "R1");
    full_write(8'b1011_101_0, 8'h03, 8'h04, 3'b000, "R1");
  endtask

  task automatic t_k4_r2;
    full_write(8'b1010_011_0, 8'h9E, 8'h3C, 3'b000, "R2");
    full_write(8'b1010_010_0, 8'h10, 8'hC3, 3'b000, "R2");
  endtask

  task automatic t_k8_r3;
    full_write(8'b1010_010_0, 8'hF0, 8'h55, 3'b000, "R3");
    full_write(8'b1010_001_0, 8'h0F, 8'hAA, 3'b000, "R3");
    full_write(8'b1010_111_0, 8'h40, 8'h99, 3'b000, "R3");
  endtask

  task automatic t_read_r5;
    full_write(8'b1010_101_1, 8'h20, 8'h21, 3'b000, "R5");
  endtask

  task automatic t_early_stop_r7;
    logic [2:0] a;
    int p = wcnt[0];
    m_start;
    m_byte(8'b1010_101_0, a);
    chk(a[0] == 1'b1, "R7", "device ack", int'(a[0]), 1);
    m_byte(8'h33, a);
    chk(a[0] == 1'b1, "R7", "address ack", int'(a[0]), 1);
    m_stop;
    tk(12);
    chk(wcnt[0] == p, "R7", "no write on early stop", wcnt[0], p);
  endtask

  task automatic t_restart_r9;
    logic [2:0] a;
    m_start;
    m_byte(8'b1010_101_0, a);
    m_byte(8'h11, a);
    chk(a[0] == 1'b1, "R9", "first address ack", int'(a[0]), 1);
    full_write(8'b1010_101_0, 8'h22, 8'h33, 3'b000, "R9");
  endtask

  task automatic t_busy_r8;
    clr[0] = 1'b0;
    full_write(8'b1010_101_0, 8'h44, 8'h45, 3'b000, "R8");
    full_write(8'b1010_101_0, 8'h46, 8'h47, 3'b001, "R8");
    clr[0] = 1'b1;
    tk(4);
    full_write(8'b1010_101_0, 8'h48, 8'h49, 3'b000, "R8");
  endtask

  task automatic t_busy_edge_r8;
    logic [2:0] a;
    int p;
    clr[0] = 1'b0;
    full_write(8'b1010_101_0, 8'h60, 8'h61, 3'b000, "R8");
    p = wcnt[0];
    sda_m = 1'b0;
    tk(1);
    clr[0] = 1'b1;
    tk(7);
    scl_m = 1'b0; tk(4);
    m_byte(8'b1010_101_0, a);
    chk(a[0] == 1'b0, "R8", "start on busy release ignored", int'(a[0]), 0);
    m_byte(8'h62, a);
    m_byte(8'h63, a);
    m_stop;
    tk(12);
    chk(wcnt[0] == p, "R8", "no write after ignored start", wcnt[0], p);
    full_write(8'b1010_101_0, 8'h64, 8'h65, 3'b000, "R8");
  endtask

  initial begin
    clr = 3'b111;
    tk(5);
    rst_n = 1'b1;
    tk(3);
    t_reset;
    t_match_r1;
    t_k4_r2;
    t_k8_r3;
    t_read_r5;
    t_early_stop_r7;
    t_restart_r9;
    t_busy_r8;
    t_busy_edge_r8;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule